// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synchronous single-port memory with a common data bus, modelled as separate data-in, data-out and drive-enable ports. Commands (address, chip selects, load strobe, write enable and byte-lane selects) are captured on the rising clock edge. Read data flows straight out of the storage in the cycle that follows the command edge. Write data is taken one enabled edge after its command. Reads and writes can therefore follow each other on every clock with no idle bus cycle.

Write data that has been captured is held in a one-entry hold register. It reaches the storage array when the next write's data is captured. A read whose address matches the held word gets the held lanes merged over the array word, so a read always sees the latest write. The block also has an active-low clock enable that freezes all state, three chip selects, two 9-bit byte lanes with active-low selects, automatic three-state control of the bus, an asynchronous output enable and a sleep input that takes effect after two clocks. Burst address sequencing is done by a neighbouring block. Here, a cycle with the load strobe high starts no access.

Top module: `zft_sram`

## Requirements
- R1: After reset the block is deselected and `dout_en` is low whatever `oe_n` is.
- R2: A read starts at an edge where `clk_en_n`=0, `cs1_n`=0, `cs2`=1, `cs3_n`=0, `ld_n`=0 and `we_n`=1. During the following cycle `dout` carries the word stored at the captured address, provided the bus is driven (R9, R10).
- R3: A write starts under the same select conditions with `we_n`=0. The `din` value present at the next enabled edge is stored, and a new command may be issued on that same edge, so writes and reads can follow each other on every cycle.
- R4: The byte-lane selects `bw_n` are active low and are captured with the write command. `bw_n[0]` covers bits 8:0 and `bw_n[1]` covers bits 17:9. Lanes whose select is high keep their old contents, so `bw_n`=2'b11 writes nothing.
- R5: A read issued on the edge that captures a write's data, or on any later edge, returns the newly written lanes, including for the same address.
- R6: At an edge with `clk_en_n`=1 nothing changes: no command is taken, a pending write keeps waiting, `din` is ignored and the bus state stays as it was.
- R7: `dout_en` stays low in the data cycle of a write, even with `oe_n`=0.
- R8: An edge with any chip select inactive, or with `ld_n`=1, starts no access, and the bus is three-stated in the cycle that follows.
- R9: A read taken on the first edge after a deselected cycle is not driven onto the bus.
- R10: `oe_n` acts without a clock. In a read cycle, `dout_en` follows the inverse of `oe_n` at once. A read issued with `oe_n`=1 leaves the bus three-stated.
- R11: `sleep`=1 forces `dout_en` low at once. From the third edge after `sleep` rises, commands are ignored. After `sleep` falls, commands are ignored for two more edges, and stored data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock qualifier; high freezes the edge |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new address and command |
| we_n | input | 1 | Low selects write, high selects read |
| bw_n | input | 2 | Byte-lane write selects, active low |
| addr | input | $clog2(DEPTH) | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| din | input | 18 | Write data bus (bus input side) |
| dout | output | 18 | Read data (bus output side), zero when not driven |
| dout_en | output | 1 | Bus drive enable |

## Verification
Storage and hold-register faults surface on `dout` in the cycle after a read command. A wrong lane mask, a lost pending write or a bad forwarding match shows as a mismatched word on the first read of that address, usually within two cycles of the write. Faults in the command or drive state show as a wrong `dout_en` level in the very next cycle: driving during a write data phase, after a deselect, during a stall or in sleep, or staying silent on a valid read. Stalls and sleep entry or exit move these effects by exactly the number of frozen or ignored edges, and the bench counts those edges when it checks.

// File: rtl/zft_pkg.sv
`timescale 1ns/1ps
package zft_pkg;
  // kind of access captured at the last enabled edge
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2
  } cyc_e;
endpackage

// File: rtl/zft_ctrl.sv
`timescale 1ns/1ps
module zft_ctrl
  import zft_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [AW-1:0]    acc_addr,
  output logic [LANES-1:0] acc_lanes,
  output logic             cap_en,
  output logic             drive_en
);
  logic             en;
  logic             chip_sel;
  logic             start;
  logic             slp1_q, slp2_q;
  cyc_e             cyc_q, cyc_n;
  logic             prev_idle_q, prev_idle_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic [LANES-1:0] lane_q, lane_n;

  assign en = ~clk_en_n;

  // command decode
  always_comb begin
    chip_sel    = ~cs1_n & cs2 & ~cs3_n;
    start       = chip_sel & ~ld_n & ~slp2_q;
    cyc_n       = CYC_IDLE;
    if (start) cyc_n = we_n ? CYC_RD : CYC_WR;
    prev_idle_n = (cyc_q == CYC_IDLE);
    addr_n      = start ? addr : addr_q;
    lane_n      = start ? ~bw_n : lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q       <= CYC_IDLE;
      prev_idle_q <= 1'b1;
      addr_q      <= '0;
      lane_q      <= '0;
    end else if (en) begin
      cyc_q       <= cyc_n;
      prev_idle_q <= prev_idle_n;
      addr_q      <= addr_n;
      lane_q      <= lane_n;
    end
  end

  // sleep request settles over two raw clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp1_q <= 1'b0;
      slp2_q <= 1'b0;
    end else begin
      slp1_q <= sleep;
      slp2_q <= slp1_q;
    end
  end

  assign acc_addr  = addr_q;
  assign acc_lanes = lane_q;
  assign cap_en    = en & (cyc_q == CYC_WR);
  assign drive_en  = (cyc_q == CYC_RD) & ~prev_idle_q & ~oe_n & ~sleep & ~slp2_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(cyc_q) && $stable(addr_q) && $stable(lane_q)));

  // R7
  wr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_WR) |-> !drive_en);

  // R9
  first_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_q == CYC_IDLE) && !clk_en_n) |=> !drive_en);

  // R11
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slp2_q && !clk_en_n) |=> (cyc_q == CYC_IDLE));
endmodule

// File: rtl/zft_wbuf.sv
`timescale 1ns/1ps
module zft_wbuf #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [AW-1:0]           cap_addr,
  input  logic [LANES-1:0]        cap_lanes,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [AW-1:0]           rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_word,
  output logic                    commit_en,
  output logic [AW-1:0]           commit_addr,
  output logic [LANES-1:0]        commit_lanes,
  output logic [LANES*LANE_W-1:0] commit_data,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DW = LANES * LANE_W;

  logic             hold_v_q;
  logic [AW-1:0]    hold_addr_q;
  logic [LANES-1:0] hold_lane_q;
  logic [DW-1:0]    hold_data_q;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v_q <= 1'b0;
    else if (cap_en) hold_v_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      hold_addr_q <= cap_addr;
      hold_lane_q <= cap_lanes;
      hold_data_q <= din;
    end
  end

  // the old held word retires as the new one arrives
  assign commit_en    = cap_en & hold_v_q;
  assign commit_addr  = hold_addr_q;
  assign commit_lanes = hold_lane_q;
  assign commit_data  = hold_data_q;

  assign hit = hold_v_q && (hold_addr_q == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_word[l*LANE_W +: LANE_W] = (hit && hold_lane_q[l])
                                         ? hold_data_q[l*LANE_W +: LANE_W]
                                         : arr_word[l*LANE_W +: LANE_W];
  end

  // R5
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v_q |=> hold_v_q);

  // R3
  hold_only_on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v_q && !cap_en) |=> ($stable(hold_addr_q) && $stable(hold_data_q) && $stable(hold_lane_q)));
endmodule

// File: rtl/zft_array.sv
`timescale 1ns/1ps
module zft_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wlanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wlanes[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/zft_sram.sv
`timescale 1ns/1ps
module zft_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] acc_lanes;
  logic             cap_en;
  logic             drive_en;
  logic             commit_en;
  logic [AW-1:0]    commit_addr;
  logic [LANES-1:0] commit_lanes;
  logic [DW-1:0]    commit_data;
  logic [DW-1:0]    arr_word;
  logic [DW-1:0]    rd_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  zft_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .clk_en_n(clk_en_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .sleep(sleep),
    .acc_addr(acc_addr), .acc_lanes(acc_lanes), .cap_en(cap_en), .drive_en(drive_en)
  );

  zft_wbuf #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n_i), .cap_en(cap_en), .cap_addr(acc_addr),
    .cap_lanes(acc_lanes), .din(din), .rd_addr(acc_addr), .arr_word(arr_word),
    .commit_en(commit_en), .commit_addr(commit_addr), .commit_lanes(commit_lanes),
    .commit_data(commit_data), .rd_word(rd_word)
  );

  zft_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_array (
    .clk(clk), .we(commit_en), .waddr(commit_addr), .wlanes(commit_lanes),
    .wdata(commit_data), .raddr(acc_addr), .rdata(arr_word)
  );

  assign dout_en = drive_en;
  assign dout    = drive_en ? rd_word : '0;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_i |=> !dout_en);
endmodule

// File: tb/tb_zft_sram.sv
`timescale 1ns/1ps
module tb_zft_sram;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n, cs1_n, cs2, cs3_n, ld_n, we_n, oe_n, sleep;
  logic [1:0]    bw_n;
  logic [AW-1:0] addr;
  logic [17:0]   din;
  logic [17:0]   dout;
  logic          dout_en;

  int n_chk = 0;
  int n_fail = 0;

  logic [17:0] ref_mem [DEPTH];
  int          cur_t = 0;
  bit          prev_idle = 1'b1;
  bit          pend_v = 1'b0;
  int          pend_a = 0;
  logic [1:0]  pend_bw = 2'b11;
  int          last_a = 0;
  bit          ign = 1'b0;

  always #4 clk = ~clk;

  zft_sram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [17:0] pat(input int a, input int s);
    logic [31:0] v;
    v = (a * 4099) ^ (s * 7919) ^ 32'h2A5A5;
    return v[17:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // kind: 0 cs1_n high, 1 read, 2 write, 3 ld_n high, 4 cs2 low, 5 cs3_n high
  task automatic issue(input int kind, input int a, input logic [1:0] bw,
                       input logic [17:0] d, input bit oe, input bit stall);
    int nt;
    clk_en_n = stall;
    cs1_n = (kind == 0);
    cs2   = (kind != 4);
    cs3_n = (kind == 5);
    ld_n  = (kind == 3);
    we_n  = (kind != 2);
    bw_n  = bw;
    addr  = a[AW-1:0];
    din   = d;
    oe_n  = oe;
    @(negedge clk);
    if (!stall) begin
      if (pend_v) begin
        if (!pend_bw[0]) ref_mem[pend_a][8:0]  = d[8:0];
        if (!pend_bw[1]) ref_mem[pend_a][17:9] = d[17:9];
      end
      nt = ign ? 0 : ((kind == 1) ? 1 : ((kind == 2) ? 2 : 0));
      prev_idle = (cur_t == 0);
      cur_t = nt;
      pend_v = (nt == 2);
      if (nt != 0) begin
        pend_a = a;
        pend_bw = bw;
        last_a = a;
      end
    end
  endtask

  task automatic check_out(input string tag);
    bit exp_en;
    exp_en = (cur_t == 1) && !prev_idle && !oe_n && !sleep;
    chk(dout_en == exp_en, tag, {17'd0, dout_en}, {17'd0, exp_en});
    if (exp_en) chk(dout == ref_mem[last_a], tag, dout, ref_mem[last_a]);
  endtask

  initial begin
    #1600000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] d;
    rst_n = 1'b0; clk_en_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0;
    ld_n = 1'b0; we_n = 1'b1; bw_n = 2'b11; addr = '0; oe_n = 1'b0; sleep = 1'b0;
    din = '0;
    repeat (3) @(negedge clk);
    // R1: reset state with oe_n low
    chk(dout_en == 1'b0, "R1 reset", {17'd0, dout_en}, 18'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_en == 1'b0, "R1 after release", {17'd0, dout_en}, 18'd0);

    // R3 back-to-back write sweep, R7 quiet data phases
    d = '0;
    for (int a = 0; a < DEPTH; a++) begin
      issue(2, a, 2'b00, d, 1'b0, 1'b0);
      check_out("R7 write data phase");
      d = pat(a, 0);
    end
    // R2 read sweep, first read directly after the last write data edge
    for (int a = 0; a < DEPTH; a++) begin
      issue(1, a, 2'b11, d, 1'b0, 1'b0);
      check_out("R2 read sweep");
    end

    // R5 write then read same address, back to back
    for (int a = 0; a < DEPTH; a++) begin
      issue(2, a, 2'b00, 18'h0, 1'b0, 1'b0);
      issue(1, a, 2'b11, pat(a, 1), 1'b0, 1'b0);
      check_out("R5 same-address read after write");
    end

    // R4 byte-lane masks, each pattern of bw_n
    for (int a = 0; a < DEPTH; a++) begin
      issue(2, a, a[1:0], 18'h0, 1'b0, 1'b0);
      issue(1, (a + 5) % DEPTH, 2'b11, pat(a, 2), 1'b0, 1'b0);
      check_out("R4 other address");
      issue(1, a, 2'b11, 18'h0, 1'b0, 1'b0);
      check_out("R4 lane merge");
    end

    // R6 stall inside a write data phase, stalled write ignored
    issue(2, 3, 2'b00, 18'h0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      issue(2, 5, 2'b00, 18'h3FFFF, 1'b0, 1'b1);
      check_out("R6 stall keeps write phase");
    end
    issue(1, 3, 2'b11, 18'h1B2C3, 1'b0, 1'b0);
    check_out("R6 data taken after stall");
    issue(1, 5, 2'b11, 18'h0, 1'b0, 1'b0);
    check_out("R6 stalled write had no effect");
    // R6 stall during a read keeps the same word on the bus
    issue(1, 7, 2'b11, 18'h0, 1'b0, 1'b0);
    check_out("R6 read before stall");
    issue(1, 8, 2'b11, 18'h0, 1'b0, 1'b1);
    check_out("R6 read held over stall");

    // R10 asynchronous output enable
    issue(1, 9, 2'b11, 18'h0, 1'b0, 1'b0);
    oe_n = 1'b1; #1;
    check_out("R10 oe_n high");
    oe_n = 1'b0; #1;
    check_out("R10 oe_n low again");
    issue(1, 10, 2'b11, 18'h0, 1'b1, 1'b0);
    check_out("R10 dummy read");

    // R8 and R9 for each deselect form
    for (int k = 0; k < 4; k++) begin
      issue((k == 0) ? 0 : k + 2, 11, 2'b11, 18'h0, 1'b0, 1'b0);
      check_out("R8 deselect quiet");
      issue(1, 12, 2'b11, 18'h0, 1'b0, 1'b0);
      check_out("R9 first read after deselect");
      issue(1, 13, 2'b11, 18'h0, 1'b0, 1'b0);
      check_out("R2 second read after deselect");
    end
    // R8 a write attempt with a select inactive changes nothing
    issue(0, 14, 2'b00, 18'h0, 1'b0, 1'b0);
    issue(1, 14, 2'b11, 18'h2AAAA, 1'b0, 1'b0);
    issue(1, 14, 2'b11, 18'h0, 1'b0, 1'b0);
    check_out("R8 ignored write");

    // R11 sleep
    issue(1, 2, 2'b11, 18'h0, 1'b0, 1'b0);
    check_out("R11 read before sleep");
    sleep = 1'b1; #1;
    chk(dout_en == 1'b0, "R11 sleep forces three-state", {17'd0, dout_en}, 18'd0);
    issue(0, 0, 2'b11, 18'h0, 1'b0, 1'b0);
    issue(0, 0, 2'b11, 18'h0, 1'b0, 1'b0);
    ign = 1'b1;
    issue(2, 9, 2'b00, 18'h0, 1'b0, 1'b0);
    issue(1, 9, 2'b11, 18'h15555, 1'b0, 1'b0);
    chk(dout_en == 1'b0, "R11 asleep", {17'd0, dout_en}, 18'd0);
    sleep = 1'b0;
    issue(0, 0, 2'b11, 18'h0, 1'b0, 1'b0);
    issue(0, 0, 2'b11, 18'h0, 1'b0, 1'b0);
    ign = 1'b0;
    issue(1, 9, 2'b11, 18'h0, 1'b0, 1'b0);
    check_out("R11 first read after wake");
    issue(1, 9, 2'b11, 18'h0, 1'b0, 1'b0);
    check_out("R11 data kept over sleep");

    // final readback of all words, R2
    for (int a = 0; a < DEPTH; a++) begin
      issue(1, a, 2'b11, 18'h0, 1'b0, 1'b0);
      check_out("R2 final readback");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule